// File: doc/BRIEF.md
# Multi-Chain Serial Test and Run Controller

This block is the whole off-chip control path of a many-core chip. It needs only a clock, one mode-select pin, a reset and a few serial data pins. A small state machine is steered by the mode-select level at each rising clock edge. It first takes in a short command on the first serial input. It then moves data through several scan chains at the same time. Each chain links a group of cores in series, and each core adds a fixed-length frame that holds an address field and a data field.

With these commands the host can load the per-core memories, read them back, start and stop program execution on all cores, and capture a status word from every core. A write puts a different address and word into each core's frame, and one update commits all of them at once. A read is pipelined: the update after one shift loads the addressed word, and the next shift brings it out. In this model each core is its frame register plus a small word memory. All cores share one run flag and one elapsed-cycle timer.

Top module: `scanlink_ctrl`

## Requirements
- R1: While reset is active, and right after it ends, every serial output is low, every core frame is zero, no core is running and the run timer reads zero.
- R2: The state machine samples mode select at each rising edge. IDLE goes to SELECT on 1. SELECT goes to data shift on 1 and command shift on 0. Both shift states go to UPDATE on 1. UPDATE goes to RUN after a run command and to HALT after a halt command; after anything else it goes to SELECT on 1 and IDLE on 0. RUN and HALT go back to IDLE on 1.
- R3: In the command shift state one bit per edge enters a 4-bit command register from serial input 0, least significant bit first. The command takes effect at the update that follows. The codes are 0 no-op, 1 write, 2 read, 3 run, 4 halt and 5 status. The codes 6 to 15 act as no-op.
- R4: In the data shift state all chains shift one bit per rising edge. Each core frame is 44 bits: bits 11:0 hold the address and bits 43:12 hold the data. Bits move toward bit 0. Serial input enters bit 43 of core 0, and each core's bit 0 feeds the next core. The first bit sent ends up in bit 0 of the last core after 44 × cores shifts.
- R5: Each serial output is registered on the falling clock edge from bit 0 of its chain's last core.
- R6: When the active command is write, the update after a data shift stores every core's data field at that core's address, in all cores at once. The chain contents are left unchanged.
- R7: A write whose address is not below the memory depth is dropped. A read of such an address returns zero data.
- R8: When the active command is read, the update after a data shift replaces each core's data field with the addressed word and keeps its address field.
- R9: After a no-op or unknown command, updates leave the chain contents unchanged. Outside data shift, read capture and status capture, the serial outputs do not change.
- R10: The run command sets the run flag and the halt command clears it, each at its update edge. The timer increases by one on every rising edge at which the flag was already set.
- R11: The status command, at its update edge, loads every frame as follows: data = timer value before that edge, address bits 11:4 = global core number (chain × cores + position), bits 3:1 = 0, bit 0 = run flag.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| scan_clk | input | 1 | Serial clock; state and chains advance on the rising edge |
| rst_n | input | 1 | Asynchronous active-low reset |
| mode_sel | input | 1 | Mode select that steers the control state machine |
| ser_in | input | NCHAIN | Serial data into each chain; bit 0 also carries commands |
| ser_out | output | NCHAIN | Serial data out of each chain, updated on the falling edge |

## Verification
Program execution and the serial commands can act on the same edge. The timer keeps counting while a status capture or a memory write update is being committed. The bench starts the cores, then issues a status capture and a memory write while they run. It checks that the captured timer equals the number of edges counted since the run update, that the run flag shows in the status, and that the word written during the run reads back intact after the halt. After the halt, a second status capture shows the timer frozen at the halt edge.

// File: rtl/slc_pkg.sv
package slc_pkg;
  localparam int ADDR_W  = 12;
  localparam int DATA_W  = 32;
  localparam int FRAME_W = ADDR_W + DATA_W;
  localparam int CMD_W   = 4;
  localparam int ID_W    = 8;

  typedef enum logic [2:0] {
    ST_IDLE, ST_SELECT, ST_SHCMD, ST_SHDAT, ST_UPDATE, ST_RUN, ST_HALT
  } state_t;

  localparam logic [CMD_W-1:0] CMD_NOP    = 4'd0;
  localparam logic [CMD_W-1:0] CMD_WRITE  = 4'd1;
  localparam logic [CMD_W-1:0] CMD_READ   = 4'd2;
  localparam logic [CMD_W-1:0] CMD_RUN    = 4'd3;
  localparam logic [CMD_W-1:0] CMD_HALT   = 4'd4;
  localparam logic [CMD_W-1:0] CMD_STATUS = 4'd5;

  // Address field of a status frame: core number on top, run flag in bit 0.
  function automatic logic [ADDR_W-1:0] status_tag(input logic [ID_W-1:0] id,
                                                   input logic run);
    return {id, {(ADDR_W-ID_W-1){1'b0}}, run};
  endfunction

  function automatic logic [FRAME_W-1:0] pack_frame(input logic [ADDR_W-1:0] addr,
                                                    input logic [DATA_W-1:0] data);
    return {data, addr};
  endfunction

  function automatic logic addr_hit(input logic [ADDR_W-1:0] addr, input int depth);
    return int'(addr) < depth;
  endfunction
endpackage

// File: rtl/slc_fsm.sv
module slc_fsm
  import slc_pkg::*;
(
  input  logic             clk,
  input  logic             rst_n,
  input  logic             mode_sel,
  input  logic             cmd_bit,
  output state_t           state,
  output logic [CMD_W-1:0] cmd_q,
  output logic             shift_ev,
  output logic             commit_ev,
  output logic             read_ev,
  output logic             status_ev,
  output logic             run_ev,
  output logic             halt_ev
);
  state_t           nxt;
  logic [CMD_W-1:0] cmd_sr;
  logic             from_cmd;
  logic             upd_cmd;
  logic             upd_dat;

  assign upd_cmd   = (state == ST_UPDATE) && from_cmd;
  assign upd_dat   = (state == ST_UPDATE) && !from_cmd;
  assign shift_ev  = (state == ST_SHDAT);
  assign commit_ev = upd_dat && (cmd_q == CMD_WRITE);
  assign read_ev   = upd_dat && (cmd_q == CMD_READ);
  assign status_ev = upd_cmd && (cmd_sr == CMD_STATUS);
  assign run_ev    = upd_cmd && (cmd_sr == CMD_RUN);
  assign halt_ev   = upd_cmd && (cmd_sr == CMD_HALT);

  always_comb begin
    nxt = state;
    case (state)
      ST_IDLE:   nxt = mode_sel ? ST_SELECT : ST_IDLE;
      ST_SELECT: nxt = mode_sel ? ST_SHDAT : ST_SHCMD;
      ST_SHCMD, ST_SHDAT: if (mode_sel) nxt = ST_UPDATE;
      ST_UPDATE: begin
        if (run_ev)       nxt = ST_RUN;
        else if (halt_ev) nxt = ST_HALT;
        else              nxt = mode_sel ? ST_SELECT : ST_IDLE;
      end
      ST_RUN, ST_HALT: if (mode_sel) nxt = ST_IDLE;
      default:   nxt = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state    <= ST_IDLE;
      cmd_sr   <= '0;
      cmd_q    <= CMD_NOP;
      from_cmd <= 1'b0;
    end else begin
      state <= nxt;
      if (state == ST_SHCMD) begin
        cmd_sr   <= {cmd_bit, cmd_sr[CMD_W-1:1]};
        from_cmd <= 1'b1;
      end else if (state == ST_SHDAT) begin
        from_cmd <= 1'b0;
      end
      if (upd_cmd) cmd_q <= cmd_sr;
    end
  end
endmodule

// File: rtl/slc_runctl.sv
module slc_runctl
  import slc_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              run_ev,
  input  logic              halt_ev,
  output logic              running,
  output logic [DATA_W-1:0] ticks
);
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      running <= 1'b0;
      ticks   <= '0;
    end else begin
      if (running) ticks <= ticks + DATA_W'(1);
      if (run_ev)       running <= 1'b1;
      else if (halt_ev) running <= 1'b0;
    end
  end
endmodule

// File: rtl/slc_core.sv
module slc_core
  import slc_pkg::*;
#(
  parameter int MEM_DEPTH = 4,
  parameter int CORE_ID   = 0
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              shift_en,
  input  logic              commit_en,
  input  logic              read_en,
  input  logic              status_en,
  input  logic              running,
  input  logic [DATA_W-1:0] ticks,
  input  logic              scan_in,
  output logic              scan_out
);
  localparam int IDX_W = (MEM_DEPTH > 1) ? $clog2(MEM_DEPTH) : 1;

  logic [FRAME_W-1:0] frame_q;
  logic [DATA_W-1:0]  mem_q [MEM_DEPTH];
  logic [ADDR_W-1:0]  f_addr;
  logic [DATA_W-1:0]  f_data;
  logic [IDX_W-1:0]   idx;
  logic               hit;

  assign f_addr   = frame_q[ADDR_W-1:0];
  assign f_data   = frame_q[FRAME_W-1:ADDR_W];
  assign idx      = f_addr[IDX_W-1:0];
  assign hit      = addr_hit(f_addr, MEM_DEPTH);
  assign scan_out = frame_q[0];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      frame_q <= '0;
    end else if (shift_en) begin
      frame_q <= {scan_in, frame_q[FRAME_W-1:1]};
    end else if (status_en) begin
      frame_q <= pack_frame(status_tag(ID_W'(CORE_ID), running), ticks);
    end else if (read_en) begin
      frame_q <= pack_frame(f_addr, hit ? mem_q[idx] : '0);
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int i = 0; i < MEM_DEPTH; i++) mem_q[i] <= '0;
    end else if (commit_en && hit) begin
      mem_q[idx] <= f_data;
    end
  end
endmodule

// File: rtl/slc_chain.sv
module slc_chain
  import slc_pkg::*;
#(
  parameter int CORES     = 16,
  parameter int MEM_DEPTH = 4,
  parameter int CHAIN_IDX = 0
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              shift_en,
  input  logic              commit_en,
  input  logic              read_en,
  input  logic              status_en,
  input  logic              running,
  input  logic [DATA_W-1:0] ticks,
  input  logic              scan_in,
  output logic              scan_out
);
  logic [CORES:0] link;

  assign link[0]  = scan_in;
  assign scan_out = link[CORES];

  for (genvar k = 0; k < CORES; k++) begin : g_core
    slc_core #(
      .MEM_DEPTH(MEM_DEPTH),
      .CORE_ID  (CHAIN_IDX * CORES + k)
    ) u_core (
      .clk      (clk),
      .rst_n    (rst_n),
      .shift_en (shift_en),
      .commit_en(commit_en),
      .read_en  (read_en),
      .status_en(status_en),
      .running  (running),
      .ticks    (ticks),
      .scan_in  (link[k]),
      .scan_out (link[k+1])
    );
  end
endmodule

// File: rtl/scanlink_ctrl.sv
module scanlink_ctrl
  import slc_pkg::*;
#(
  parameter int NCHAIN    = 4,
  parameter int CORES     = 16,
  parameter int MEM_DEPTH = 4
) (
  input  logic              scan_clk,
  input  logic              rst_n,
  input  logic              mode_sel,
  input  logic [NCHAIN-1:0] ser_in,
  output logic [NCHAIN-1:0] ser_out
);
  state_t            fsm_state;
  logic [CMD_W-1:0]  cmd_q;
  logic              shift_ev;
  logic              commit_ev;
  logic              read_ev;
  logic              status_ev;
  logic              run_ev;
  logic              halt_ev;
  logic              running;
  logic [DATA_W-1:0] ticks;
  logic [NCHAIN-1:0] tail;

  slc_fsm u_fsm (
    .clk      (scan_clk),
    .rst_n    (rst_n),
    .mode_sel (mode_sel),
    .cmd_bit  (ser_in[0]),
    .state    (fsm_state),
    .cmd_q    (cmd_q),
    .shift_ev (shift_ev),
    .commit_ev(commit_ev),
    .read_ev  (read_ev),
    .status_ev(status_ev),
    .run_ev   (run_ev),
    .halt_ev  (halt_ev)
  );

  slc_runctl u_run (
    .clk    (scan_clk),
    .rst_n  (rst_n),
    .run_ev (run_ev),
    .halt_ev(halt_ev),
    .running(running),
    .ticks  (ticks)
  );

  for (genvar c = 0; c < NCHAIN; c++) begin : g_chain
    slc_chain #(
      .CORES    (CORES),
      .MEM_DEPTH(MEM_DEPTH),
      .CHAIN_IDX(c)
    ) u_chain (
      .clk      (scan_clk),
      .rst_n    (rst_n),
      .shift_en (shift_ev),
      .commit_en(commit_ev),
      .read_en  (read_ev),
      .status_en(status_ev),
      .running  (running),
      .ticks    (ticks),
      .scan_in  (ser_in[c]),
      .scan_out (tail[c])
    );
  end

  always_ff @(negedge scan_clk or negedge rst_n) begin
    if (!rst_n) ser_out <= '0;
    else        ser_out <= tail;
  end
endmodule

// File: rtl/slc_chk.sv
module slc_chk
  import slc_pkg::*;
#(
  parameter int NCHAIN = 4
) (
  input logic              clk,
  input logic              rst_n,
  input logic              mode_sel,
  input state_t            state,
  input logic [CMD_W-1:0]  cmd_q,
  input logic              shift_ev,
  input logic              read_ev,
  input logic              status_ev,
  input logic              run_ev,
  input logic              halt_ev,
  input logic              running,
  input logic [DATA_W-1:0] ticks,
  input logic [NCHAIN-1:0] tail,
  input logic [NCHAIN-1:0] ser_out
);
  p_idle_hold_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (state == ST_IDLE && !mode_sel) |=> (state == ST_IDLE));

  p_select_cmd_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (state == ST_SELECT && !mode_sel) |=> (state == ST_SHCMD));

  p_cmd_hold_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (state != ST_UPDATE) |=> $stable(cmd_q));

  p_out_follow_r5: assert property (@(posedge clk) disable iff (!rst_n)
    ser_out == tail);

  p_chain_hold_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (!shift_ev && !read_ev && !status_ev) |=> $stable(tail));

  p_run_set_r10: assert property (@(posedge clk) disable iff (!rst_n)
    run_ev |=> running);

  p_halt_clr_r10: assert property (@(posedge clk) disable iff (!rst_n)
    halt_ev |=> !running);

  p_tick_step_r10: assert property (@(posedge clk) disable iff (!rst_n)
    running |=> (ticks == $past(ticks) + DATA_W'(1)));
endmodule

bind scanlink_ctrl slc_chk #(.NCHAIN(NCHAIN)) u_chk (
  .clk      (scan_clk),
  .rst_n    (rst_n),
  .mode_sel (mode_sel),
  .state    (fsm_state),
  .cmd_q    (cmd_q),
  .shift_ev (shift_ev),
  .read_ev  (read_ev),
  .status_ev(status_ev),
  .run_ev   (run_ev),
  .halt_ev  (halt_ev),
  .running  (running),
  .ticks    (ticks),
  .tail     (tail),
  .ser_out  (ser_out)
);

// File: tb/sim_scanlink_ctrl.sv
module sim_scanlink_ctrl;
  localparam int NCH = 4;
  localparam int CPC = 16;
  localparam int MD  = 4;
  localparam int FW  = 44;
  localparam int LEN = FW * CPC;

  logic           clk   = 1'b0;
  logic           rst_n = 1'b0;
  logic           mode  = 1'b0;
  logic [NCH-1:0] sin   = '0;
  logic [NCH-1:0] sout;

  always #5 clk = ~clk;

  scanlink_ctrl #(.NCHAIN(NCH), .CORES(CPC), .MEM_DEPTH(MD)) u0 (
    .scan_clk(clk), .rst_n(rst_n), .mode_sel(mode), .ser_in(sin), .ser_out(sout)
  );

  typedef struct {string req; logic [FW-1:0] v; int c; int k;} item_t;
  item_t exp_q[$];
  item_t got_q[$];

  int          n_cmp = 0;
  int          n_bad = 0;
  logic [31:0] tick_m = '0;
  bit          run_m  = 1'b0;
  logic [31:0] snap_t;
  bit          snap_r;
  bit          finished = 1'b0;
  logic [FW-1:0] fin  [NCH][CPC];
  logic [FW-1:0] fout [NCH][CPC];

  function automatic logic [FW-1:0] pat(input int s, input int c, input int k);
    logic [31:0] h = (32'(s) * 32'h9E3779B1) ^ 32'(c * 977 + k * 131 + 1);
    return {h, h[11:0] ^ 12'(s * 7 + k)};
  endfunction

  function automatic logic [31:0] wdat(input int r, input int c, input int k);
    return 32'h1000_0000 + 32'(r * 4096 + c * 256 + k * 3);
  endfunction

  function automatic logic [FW-1:0] stat(input int c, input int k, input bit r,
                                         input logic [31:0] t);
    return {t, 8'(c * CPC + k), 3'b000, r};
  endfunction

  // Scoreboard monitor: pairs driver expectations with captured frames.
  always @(posedge clk) begin
    while (exp_q.size() > 0 && got_q.size() > 0) begin
      item_t e;
      item_t g;
      e = exp_q.pop_front();
      g = got_q.pop_front();
      n_cmp++;
      if (g.v !== e.v) begin
        n_bad++;
        $display("FAIL %s chain %0d core %0d: got %h expected %h", e.req, e.c, e.k, g.v, e.v);
      end
    end
  end

  task automatic check(input string req, input logic [63:0] act, input logic [63:0] expv);
    n_cmp++;
    if (act !== expv) begin
      n_bad++;
      $display("FAIL %s: got %h expected %h", req, act, expv);
    end
  endtask

  task automatic push_exp(input string req, input int c, input int k, input logic [FW-1:0] v);
    item_t e;
    e.req = req; e.c = c; e.k = k; e.v = v;
    exp_q.push_back(e);
  endtask

  task automatic cyc(input logic m, input logic [NCH-1:0] d, output logic [NCH-1:0] so);
    @(negedge clk);
    #1;
    so   = sout;
    mode = m;
    sin  = d;
    @(posedge clk);
    if (run_m) tick_m = tick_m + 32'd1;
  endtask

  task automatic idle(input int n);
    logic [NCH-1:0] so;
    for (int i = 0; i < n; i++) cyc(1'b0, '0, so);
  endtask

  task automatic send_cmd(input logic [3:0] code);
    logic [NCH-1:0] so;
    cyc(1'b1, '0, so);
    cyc(1'b0, '0, so);
    for (int i = 0; i < 4; i++) cyc(i == 3, {3'b000, code[i]}, so);
    if (code == 4'd5) begin
      snap_t = tick_m;
      snap_r = run_m;
    end
    cyc(1'b0, '0, so);
    if (code == 4'd3) run_m = 1'b1;
    if (code == 4'd4) run_m = 1'b0;
    if (code == 4'd3 || code == 4'd4) cyc(1'b1, '0, so);
  endtask

  task automatic shift_data(input bit keep);
    logic [NCH-1:0] d;
    logic [NCH-1:0] so;
    cyc(1'b1, '0, so);
    cyc(1'b1, '0, so);
    for (int j = 0; j < LEN; j++) begin
      int k = CPC - 1 - j / FW;
      int b = j % FW;
      for (int c = 0; c < NCH; c++) d[c] = fin[c][k][b];
      cyc(j == LEN - 1, d, so);
      for (int c = 0; c < NCH; c++) fout[c][k][b] = so[c];
    end
    cyc(1'b0, '0, so);
    if (keep) begin
      for (int c = 0; c < NCH; c++) begin
        for (int k = 0; k < CPC; k++) begin
          item_t g;
          g.req = ""; g.c = c; g.k = k; g.v = fout[c][k];
          got_q.push_back(g);
        end
      end
    end
  endtask

  task automatic finish_run();
    if (!finished) begin
      finished = 1'b1;
      $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
    end
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    n_cmp++;
    n_bad++;
    $display("FAIL watchdog: got timeout expected completion");
    finish_run();
  end

  initial begin
    repeat (3) @(posedge clk);
    #1;
    check("R1 output during reset", 64'(sout), 64'd0);
    @(negedge clk);
    rst_n = 1'b1;
    #1;
    check("R1 output after reset", 64'(sout), 64'd0);

    // R1: frames are zero after reset
    for (int c = 0; c < NCH; c++)
      for (int k = 0; k < CPC; k++) begin
        fin[c][k] = pat(1, c, k);
        push_exp("R1 reset frame", c, k, '0);
      end
    shift_data(1'b1);

    // R11: status capture right after reset (timer zero, not running)
    send_cmd(4'd5);
    for (int c = 0; c < NCH; c++)
      for (int k = 0; k < CPC; k++) begin
        fin[c][k] = pat(2, c, k);
        push_exp("R11 status after reset", c, k, stat(c, k, snap_r, snap_t));
      end
    shift_data(1'b1);

    // R2 R4 R5: loopback through a no-op
    send_cmd(4'd0);
    for (int c = 0; c < NCH; c++)
      for (int k = 0; k < CPC; k++) begin
        push_exp("R2 R4 R5 loopback", c, k, pat(2, c, k));
        fin[c][k] = pat(3, c, k);
      end
    shift_data(1'b1);

    // R3 R9: unknown code acts as no-op
    send_cmd(4'd9);
    for (int c = 0; c < NCH; c++)
      for (int k = 0; k < CPC; k++) begin
        push_exp("R3 R9 unknown command", c, k, pat(3, c, k));
        fin[c][k] = pat(4, c, k);
      end
    shift_data(1'b1);

    // R6: write rounds, one address per round
    send_cmd(4'd1);
    for (int r = 0; r < MD; r++) begin
      for (int c = 0; c < NCH; c++)
        for (int k = 0; k < CPC; k++) begin
          if (r == 0) push_exp("R9 chain before write", c, k, pat(4, c, k));
          fin[c][k] = {wdat(r, c, k), 12'(r)};
        end
      shift_data(r == 0);
    end
    // R7: writes beyond the depth must be dropped
    for (int c = 0; c < NCH; c++)
      for (int k = 0; k < CPC; k++) fin[c][k] = {~wdat(0, c, k), 12'(MD + k)};
    shift_data(1'b0);

    // R8 R7: pipelined reads of addresses 0..MD-1, then an out-of-range one
    send_cmd(4'd2);
    for (int i = 0; i <= MD + 1; i++) begin
      for (int c = 0; c < NCH; c++)
        for (int k = 0; k < CPC; k++) begin
          if (i == 0) push_exp("R6 commit keeps chain", c, k, {~wdat(0, c, k), 12'(MD + k)});
          else if (i <= MD) push_exp("R8 R7 read word", c, k, {wdat(i - 1, c, k), 12'(i - 1)});
          else push_exp("R7 out-of-range read", c, k, {32'd0, 12'(MD + 1)});
          fin[c][k] = {32'd0, (i < MD) ? 12'(i) : 12'(MD + 1)};
        end
      shift_data(1'b1);
    end

    // R10 R11: run, then status and a write while running
    send_cmd(4'd3);
    idle(37);
    send_cmd(4'd5);
    for (int c = 0; c < NCH; c++)
      for (int k = 0; k < CPC; k++) begin
        push_exp("R10 R11 status while running", c, k, stat(c, k, 1'b1, snap_t));
        fin[c][k] = pat(5, c, k);
      end
    check("R10 bench run flag", 64'(snap_r), 64'd1);
    shift_data(1'b1);

    send_cmd(4'd1);
    for (int c = 0; c < NCH; c++)
      for (int k = 0; k < CPC; k++) fin[c][k] = {32'hA5A5_0000 ^ 32'(c * 64 + k), 12'd2};
    shift_data(1'b0);

    send_cmd(4'd5);
    for (int c = 0; c < NCH; c++)
      for (int k = 0; k < CPC; k++) push_exp("R10 timer after write", c, k, stat(c, k, 1'b1, snap_t));
    shift_data(1'b1);

    // R10: halt freezes the timer
    send_cmd(4'd4);
    idle(20);
    send_cmd(4'd5);
    for (int c = 0; c < NCH; c++)
      for (int k = 0; k < CPC; k++) push_exp("R10 status after halt", c, k, stat(c, k, 1'b0, snap_t));
    shift_data(1'b1);

    // R6: word written during the run reads back
    send_cmd(4'd2);
    for (int c = 0; c < NCH; c++)
      for (int k = 0; k < CPC; k++) fin[c][k] = {32'd0, 12'd2};
    shift_data(1'b0);
    for (int c = 0; c < NCH; c++)
      for (int k = 0; k < CPC; k++) begin
        push_exp("R6 write during run", c, k, {32'hA5A5_0000 ^ 32'(c * 64 + k), 12'd2});
        fin[c][k] = '0;
      end
    shift_data(1'b1);

    idle(3);
    check("R4 scoreboard drained", 64'(exp_q.size()), 64'd0);
    finish_run();
  end
endmodule